// File: doc/BRIEF.md
# Multiplicative Boost Frequency Governor

This block turns threshold-crossing events from an activity monitor into a frequency request. It keeps a boost term in kHz. An "up" event multiplies the boost by an up coefficient (in percent), adds a fixed step and caps the result at a ceiling frequency. A "down" event multiplies the boost by a down coefficient (in percent). A down result that falls below half the step is forced to zero. After each event the block forms a registered target frequency. This target is the average activity count divided by the sampling period, scaled by a sustain factor derived from the up threshold, plus the new boost.

The block also drives two enable outputs that tell the monitor whether further up or down events are wanted. An up event that saturates at the ceiling switches off up events. A down event that reaches zero switches off down events. When a non-zero dependency threshold is supplied, the average count can force down events back on. A single shared iterative divider performs every division, so each event takes a fixed multi-cycle sequence. A one-cycle completion strobe marks the cycle in which all outputs take their new values.

Top module: `boost_governor`

## Requirements
- R1: After reset, boost_o and target_o are 0, up_en_o and dn_en_o are 1, and done_o is 0.
- R2: On an accepted up event, the new boost is floor(old_boost * up_coef / 100) + 16000. If that value is greater than or equal to max_freq, the boost becomes max_freq and up_en_o goes to 0; otherwise up_en_o is 1. dn_en_o is 1 unless R5 clears it.
- R3: On an accepted down event, the new boost is floor(old_boost * dn_coef / 100), with dn_coef no larger than 100. If that value is below 8000, the boost becomes 0 and dn_en_o goes to 0; otherwise dn_en_o is 1. up_en_o is 1.
- R4: When up_evt and dn_evt are both high in the accepting cycle, the event is handled as an up event.
- R5: When dep_thresh is non-zero, dn_en_o is forced to 1 if avg_count >= dep_thresh. It is forced to 0 if avg_count < dep_thresh and the new boost is 0. When dep_thresh is 0, R2 and R3 alone set dn_en_o.
- R6: target_o = floor(floor(floor(avg_count / 12) * floor(10000 / up_thresh)) / 100) + new boost. The result saturates at 2^32-1. up_thresh must be non-zero.
- R7: Each accepted event produces exactly one done_o pulse, one cycle wide. boost_o, target_o, up_en_o and dn_en_o all change in that same cycle.
- R8: An event is accepted only while the block is idle. Events that arrive during a computation are ignored. All operand inputs are captured in the accepting cycle, so later changes to them do not affect the result in progress.
- R9: Between done_o pulses, boost_o, target_o, up_en_o and dn_en_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_evt | input | 1 | Up event pulse from the activity monitor |
| dn_evt | input | 1 | Down event pulse from the activity monitor |
| avg_count | input | 32 | Average activity count for the sampling window |
| up_coef | input | 10 | Up multiplier in percent |
| dn_coef | input | 10 | Down multiplier in percent |
| up_thresh | input | 8 | Up threshold in percent, sets the sustain factor |
| dep_thresh | input | 32 | Dependency threshold for the average count, 0 disables it |
| max_freq | input | 32 | Ceiling frequency in kHz |
| boost_o | output | 32 | Current boost in kHz |
| target_o | output | 32 | Registered target frequency in kHz |
| up_en_o | output | 1 | Up events wanted |
| dn_en_o | output | 1 | Down events wanted |
| done_o | output | 1 | One-cycle strobe: new outputs valid |

## Verification
The embedded assertions check several invariants on every cycle: a disabled down direction always goes with a zero boost; a disabled up direction at completion goes with a boost equal to the captured ceiling; done_o is never two cycles wide; the outputs stay frozen between strobes; up has priority at acceptance; and the divider is never restarted while busy. The exact arithmetic can only be shown by the bench's scenarios. These include the growth sequence up to the ceiling, the decay to zero with its snap, both coefficient sets, the dependency override, the saturation of the target sum, and the use of captured operands when inputs change mid-computation. Each of these outcomes is compared against a behavioural integer model on every clock.

// File: rtl/bg_pkg.sv
package bg_pkg;
    localparam int BG_FW      = 32;
    localparam int BG_CW      = 10;
    localparam int BG_TW      = 8;
    localparam int BG_PERIOD  = 12;
    localparam int BG_STEP    = 16000;
    localparam int BG_PCT     = 100;
    localparam int BG_SUSTAIN = 10000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCALE,
        ST_AVG,
        ST_SUS,
        ST_TGT
    } bg_state_e;
endpackage

// File: rtl/bg_div.sv
module bg_div #(
    parameter int DW = 48
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] quotient
);
    localparam int CNTW = $clog2(DW + 1);

    logic [DW-1:0]   rem_q, quo_q;
    logic [CNTW-1:0] cnt_q;
    logic [DW:0]     rem_sh, diff;
    logic            fits;

    always_comb begin
        rem_sh = {rem_q, quo_q[DW-1]};
        diff   = rem_sh - {1'b0, divisor};
        fits   = !diff[DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            rem_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q <= '0;
                quo_q <= dividend;
                cnt_q <= CNTW'(DW);
                busy  <= 1'b1;
            end else if (busy) begin
                rem_q <= fits ? diff[DW-1:0] : rem_sh[DW-1:0];
                quo_q <= {quo_q[DW-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNTW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;

    // R8: a new division is only launched on an idle divider
    p_start_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    // R7: completion only follows a running division
    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));
endmodule

// File: rtl/bg_rules.sv
module bg_rules #(
    parameter int FW   = 32,
    parameter int DW   = 48,
    parameter int STEP = 16000
) (
    input  logic          is_up,
    input  logic [DW-1:0] scaled,
    input  logic [FW-1:0] max_f,
    input  logic [FW-1:0] avg,
    input  logic [FW-1:0] dep,
    output logic [FW-1:0] boost_o,
    output logic          up_en_o,
    output logic          dn_en_o
);
    localparam logic [DW-1:0] STEP_W = DW'(STEP);
    localparam logic [DW-1:0] SNAP_W = DW'(STEP / 2);

    logic [DW-1:0] stepped;

    always_comb begin
        stepped = scaled + STEP_W;
        up_en_o = 1'b1;
        dn_en_o = 1'b1;
        if (is_up) begin
            if (stepped >= DW'(max_f)) begin
                boost_o = max_f;
                up_en_o = 1'b0;
            end else begin
                boost_o = stepped[FW-1:0];
            end
        end else begin
            if (scaled < SNAP_W) begin
                boost_o = '0;
                dn_en_o = 1'b0;
            end else begin
                boost_o = scaled[FW-1:0];
            end
        end
        if (dep != '0) begin
            if (avg >= dep)
                dn_en_o = 1'b1;
            else if (boost_o == '0)
                dn_en_o = 1'b0;
        end
    end
endmodule

// File: rtl/boost_governor.sv
module boost_governor
    import bg_pkg::*;
#(
    parameter int FW      = BG_FW,
    parameter int CW      = BG_CW,
    parameter int TW      = BG_TW,
    parameter int PERIOD  = BG_PERIOD,
    parameter int STEP    = BG_STEP
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          up_evt,
    input  logic          dn_evt,
    input  logic [FW-1:0] avg_count,
    input  logic [CW-1:0] up_coef,
    input  logic [CW-1:0] dn_coef,
    input  logic [TW-1:0] up_thresh,
    input  logic [FW-1:0] dep_thresh,
    input  logic [FW-1:0] max_freq,
    output logic [FW-1:0] boost_o,
    output logic [FW-1:0] target_o,
    output logic          up_en_o,
    output logic          dn_en_o,
    output logic          done_o
);
    localparam int DW = FW + 16;
    localparam logic [DW-1:0] FMAX_W = DW'({FW{1'b1}});

    bg_state_e     st_q;
    logic          is_up_q;
    logic [CW-1:0] coef_q;
    logic [TW-1:0] uth_q;
    logic [FW-1:0] avg_q, dep_q, max_q;
    logic [FW-1:0] nb_q;
    logic          nue_q, nde_q;
    logic [DW-1:0] q1_q;

    logic          div_start_q, div_busy, div_done;
    logic [DW-1:0] div_a_q, div_b_q, div_q;

    logic [FW-1:0] rb;
    logic          rue, rde;
    logic [DW-1:0] sum;

    bg_div #(.DW(DW)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start_q),
        .dividend (div_a_q),
        .divisor  (div_b_q),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_q)
    );

    bg_rules #(.FW(FW), .DW(DW), .STEP(STEP)) u_rules (
        .is_up   (is_up_q),
        .scaled  (div_q),
        .max_f   (max_q),
        .avg     (avg_q),
        .dep     (dep_q),
        .boost_o (rb),
        .up_en_o (rue),
        .dn_en_o (rde)
    );

    assign sum = div_q + DW'(nb_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            is_up_q     <= 1'b0;
            coef_q      <= '0;
            uth_q       <= '0;
            avg_q       <= '0;
            dep_q       <= '0;
            max_q       <= '0;
            nb_q        <= '0;
            nue_q       <= 1'b1;
            nde_q       <= 1'b1;
            q1_q        <= '0;
            div_start_q <= 1'b0;
            div_a_q     <= '0;
            div_b_q     <= '0;
            boost_o     <= '0;
            target_o    <= '0;
            up_en_o     <= 1'b1;
            dn_en_o     <= 1'b1;
            done_o      <= 1'b0;
        end else begin
            div_start_q <= 1'b0;
            done_o      <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (up_evt || dn_evt) begin
                    is_up_q     <= up_evt;
                    coef_q      <= up_evt ? up_coef : dn_coef;
                    uth_q       <= up_thresh;
                    avg_q       <= avg_count;
                    dep_q       <= dep_thresh;
                    max_q       <= max_freq;
                    div_a_q     <= DW'(boost_o) * DW'(up_evt ? up_coef : dn_coef);
                    div_b_q     <= DW'(BG_PCT);
                    div_start_q <= 1'b1;
                    st_q        <= ST_SCALE;
                end
                ST_SCALE: if (div_done) begin
                    nb_q        <= rb;
                    nue_q       <= rue;
                    nde_q       <= rde;
                    div_a_q     <= DW'(avg_q);
                    div_b_q     <= DW'(PERIOD);
                    div_start_q <= 1'b1;
                    st_q        <= ST_AVG;
                end
                ST_AVG: if (div_done) begin
                    q1_q        <= div_q;
                    div_a_q     <= DW'(BG_SUSTAIN);
                    div_b_q     <= DW'(uth_q);
                    div_start_q <= 1'b1;
                    st_q        <= ST_SUS;
                end
                ST_SUS: if (div_done) begin
                    div_a_q     <= q1_q * div_q;
                    div_b_q     <= DW'(BG_PCT);
                    div_start_q <= 1'b1;
                    st_q        <= ST_TGT;
                end
                ST_TGT: if (div_done) begin
                    target_o <= (sum > FMAX_W) ? {FW{1'b1}} : sum[FW-1:0];
                    boost_o  <= nb_q;
                    up_en_o  <= nue_q;
                    dn_en_o  <= nde_q;
                    done_o   <= 1'b1;
                    st_q     <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R2: a switched-off up direction means the boost sits at the ceiling
    p_upoff_at_max_r2: assert property (@(posedge clk) disable iff (rst)
        (done_o && !up_en_o) |-> (boost_o == max_q));
    // R3: a switched-off down direction always goes with a zero boost
    p_dnoff_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !dn_en_o |-> (boost_o == '0));
    // R4: simultaneous pulses are taken as an up event
    p_up_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && up_evt) |=> (is_up_q && st_q == ST_SCALE));
    // R7: completion strobe lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R9: outputs frozen except on the strobe
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(boost_o) && $stable(target_o) &&
                     $stable(up_en_o) && $stable(dn_en_o)));
endmodule

// File: tb/boost_governor_tb.sv
module boost_governor_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        up_evt = 1'b0, dn_evt = 1'b0;
    logic [31:0] avg_count = '0;
    logic [9:0]  up_coef = 10'd200, dn_coef = 10'd50;
    logic [7:0]  up_thresh = 8'd60;
    logic [31:0] dep_thresh = '0;
    logic [31:0] max_freq = 32'd800000;
    logic [31:0] boost_o, target_o;
    logic        up_en_o, dn_en_o, done_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    boost_governor u_dut (
        .clk(clk), .rst(rst), .up_evt(up_evt), .dn_evt(dn_evt),
        .avg_count(avg_count), .up_coef(up_coef), .dn_coef(dn_coef),
        .up_thresh(up_thresh), .dep_thresh(dep_thresh), .max_freq(max_freq),
        .boost_o(boost_o), .target_o(target_o), .up_en_o(up_en_o),
        .dn_en_o(dn_en_o), .done_o(done_o)
    );

    int    nchk = 0, nfail = 0;
    string cur_req = "R1";
    longint mb = 0, mt = 0;
    bit     mue = 1, mde = 1;
    longint pb = 0, pt = 0;
    bit     pue = 1, pde = 1;
    bit     pend = 0, prev_done = 0;

    task automatic cmp(string what, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic model_eval(bit u);
        longint s, b, t, lim;
        bit ue, de;
        ue = 1; de = 1;
        if (u) begin
            b = (mb * longint'(up_coef)) / 100 + 16000;
            if (b >= longint'(max_freq)) begin b = longint'(max_freq); ue = 0; end
        end else begin
            b = (mb * longint'(dn_coef)) / 100;
            if (b < 8000) begin b = 0; de = 0; end
        end
        if (dep_thresh != 0) begin
            if (avg_count >= dep_thresh) de = 1;
            else if (b == 0) de = 0;
        end
        s = ((longint'(avg_count) / 12) * (10000 / longint'(up_thresh))) / 100;
        t = s + b;
        lim = 64'h0000_0000_FFFF_FFFF;
        if (t > lim) t = lim;
        pb = b; pt = t; pue = ue; pde = de;
    endtask

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (done_o) begin
            if (!pend) cmp("unexpected done", 1, 0);
            else begin mb = pb; mt = pt; mue = pue; mde = pde; pend = 0; end
            if (prev_done) cmp("done width", 2, 1);
        end
        prev_done = done_o;
        cmp("done", longint'(done_o), 0 + (done_o && !pend ? 1 : 0));
        cmp("boost", longint'(boost_o), mb);
        cmp("target", longint'(target_o), mt);
        cmp("up_en", longint'(up_en_o), longint'(mue));
        cmp("dn_en", longint'(dn_en_o), longint'(mde));
    endtask

    task automatic fire(bit u, bit d);
        up_evt = u; dn_evt = d;
        if (!pend && !rst && (u || d)) begin model_eval(u); pend = 1; end
        tick();
        up_evt = 0; dn_evt = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && pend; i++) tick();
        if (pend) begin
            cmp("done timeout", 0, 1);
            pend = 0;
        end
    endtask

    task automatic ev(bit u, bit d);
        fire(u, d);
        wait_done();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        // R1: reset values
        cur_req = "R1";
        repeat (3) tick();
        rst = 0;
        tick();
        cmp("reset boost", longint'(boost_o), 0);
        cmp("reset up_en", longint'(up_en_o), 1);

        // R2: growth 16000, 48000, 112000, 240000, 496000, then ceiling 800000
        cur_req = "R2";
        avg_count = 32'd1200000;
        for (int k = 0; k < 6; k++) ev(1, 0);
        cmp("R2 ceiling boost", longint'(boost_o), 800000);
        cmp("R2 up disabled", longint'(up_en_o), 0);

        // R3: decay to zero with snap, down disabled
        cur_req = "R3";
        for (int k = 0; k < 7; k++) ev(0, 1);
        cmp("R3 snapped boost", longint'(boost_o), 0);
        cmp("R3 dn disabled", longint'(dn_en_o), 0);
        cmp("R3 up enabled", longint'(up_en_o), 1);

        // R2/R3 with the second coefficient set
        cur_req = "R2";
        up_coef = 10'd800; dn_coef = 10'd90; up_thresh = 8'd27;
        ev(1, 0); ev(1, 0); ev(1, 0);
        cur_req = "R3";
        ev(0, 1); ev(0, 1);

        // R4: both pulses together act as up
        cur_req = "R4";
        ev(1, 1);
        cmp("R4 up taken", longint'(boost_o) > 16000 ? 1 : 0, 1);

        // R5: dependency threshold override
        cur_req = "R5";
        dep_thresh = 32'd50000; up_coef = 10'd200; dn_coef = 10'd50;
        avg_count = 32'd60000;
        for (int k = 0; k < 12; k++) ev(0, 1);
        cmp("R5 dn forced on", longint'(dn_en_o), 1);
        avg_count = 32'd100;
        ev(0, 1);
        cmp("R5 dn forced off", longint'(dn_en_o), 0);
        dep_thresh = '0;

        // R8: events and input changes during a computation are ignored
        cur_req = "R8";
        avg_count = 32'd500000;
        fire(1, 0);
        repeat (5) tick();
        up_coef = 10'd900; avg_count = 32'd7; max_freq = 32'd20000;
        fire(0, 1);
        fire(1, 0);
        wait_done();
        for (int k = 0; k < 20; k++) tick();
        max_freq = 32'd800000; up_coef = 10'd200;

        // R6: target saturation and small-threshold sustain
        cur_req = "R6";
        avg_count = 32'hFFFF_FFFF; up_thresh = 8'd1;
        ev(1, 0);
        cmp("R6 saturated target", longint'(target_o), 64'h0000_0000_FFFF_FFFF);
        avg_count = 32'd2400000; up_thresh = 8'd40;
        ev(0, 1);

        // R7, R9: quiet period, nothing changes, no strobe
        cur_req = "R9";
        for (int k = 0; k < 30; k++) tick();

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule